// File: doc/BRIEF.md
# Dual-Rail Iterative Magnitude Comparator

This block compares two unsigned N-bit numbers, `a` and `b`, whose bits arrive in dual-rail form. Each bit travels on a pair of wires: the true wire high with the false wire low means 1, and the reverse means 0. Both wires low is the null (spacer) state and means the bit has not arrived yet. Both wires high is an illegal code and is treated as not arrived.

The comparison is a linear chain of identical cells that runs from the most significant bit to the least significant one. Each cell hands the next a one-hot ordering token: pending, equal, greater or less. A cell that receives greater or less passes it on unchanged. A cell that receives equal resolves its own bit pair. Any cell whose bit pair is not valid, or that receives pending, sends pending. The last cell drives the outputs. Completion therefore comes from the data itself and not from a timing assumption. Surrounding asynchronous logic waits for `done` before it uses the result.

The block is purely combinational, and the width is a parameter.

Top module: `dr_mag_compare`

## Requirements
- R1: With every rail low (all bits null), `done`, `gt`, `eq` and `lt` are all 0.
- R2: While any bit pair of `a` or `b` is null (both wires low), `done` is 0 and `gt`, `eq` and `lt` are all 0, however many other bits are valid.
- R3: A bit pair with both wires high counts as not valid. While one is present, `done` stays 0.
- R4: As soon as every bit pair of both operands holds a valid code (true=1/false=0 encodes 1, true=0/false=1 encodes 0), `done` is 1. It rises only when the last missing bit arrives, whatever the order of arrival.
- R5: With `done` at 1, `gt` is 1 exactly when `a` > `b` as unsigned integers.
- R6: With `done` at 1, `lt` is 1 exactly when `a` < `b` as unsigned integers.
- R7: With `done` at 1, `eq` is 1 exactly when `a` == `b`.
- R8: With `done` at 1, exactly one of `gt`, `eq` and `lt` is 1. Every inter-cell token is one-hot among its four states.
- R9: The most significant differing bit alone decides the result. Lower bits that disagree the other way (for example `a`=0x80, `b`=0x7F) do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_t | input | N | True rails of operand a |
| a_f | input | N | False rails of operand a |
| b_t | input | N | True rails of operand b |
| b_f | input | N | False rails of operand b |
| gt | output | 1 | a greater than b (valid with done) |
| eq | output | 1 | a equal to b (valid with done) |
| lt | output | 1 | a less than b (valid with done) |
| done | output | 1 | All bits valid and result settled |

## Verification
The bench builds the comparator twice. The N=8 instance carries a table of operand pairs that covers equal values, the extreme values 0x00 and 0xFF, and a most-significant-bit win against opposing lower bits. In that instance the sixteen bit pairs arrive one at a time in a shuffled order, so `done` can be checked after every arrival. The N=1 instance reaches the degenerate chain, where one cell is both the first and the last and must resolve all four bit combinations. Directed cases on the N=8 instance add an illegal both-high bit and an operand left entirely null.

// File: rtl/dr_mag_compare.sv
module dr_mag_compare #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_t,
  input  logic [N-1:0] a_f,
  input  logic [N-1:0] b_t,
  input  logic [N-1:0] b_f,
  output logic         gt,
  output logic         eq,
  output logic         lt,
  output logic         done
);
  // one-hot token: bit0 pending, bit1 equal, bit2 greater, bit3 less
  localparam logic [3:0] S_PEND = 4'b0001;
  localparam logic [3:0] S_EQ   = 4'b0010;
  localparam logic [3:0] S_GT   = 4'b0100;
  localparam logic [3:0] S_LT   = 4'b1000;

  logic [N-1:0] ok;
  assign ok = (a_t ^ a_f) & (b_t ^ b_f);

  for (genvar i = N - 1; i >= 0; i--) begin : g_cell
    logic [3:0] prev;
    logic [3:0] st;

    if (i == N - 1) begin : g_head
      assign prev = S_EQ;
    end else begin : g_link
      assign prev = g_cell[i+1].st;
    end

    always_comb begin
      if (!ok[i] || prev[0])        st = S_PEND;
      else if (prev[2])             st = S_GT;
      else if (prev[3])             st = S_LT;
      else if (a_t[i] && b_f[i])    st = S_GT;
      else if (a_f[i] && b_t[i])    st = S_LT;
      else                          st = S_EQ;
    end

    always_comb begin
      assert_link_onehot_R8: assert ($onehot(st));
    end
  end

  logic [3:0] fin;
  assign fin  = g_cell[0].st;
  assign gt   = fin[2];
  assign eq   = fin[1];
  assign lt   = fin[3];
  assign done = ~fin[0] & (&ok);

  always_comb begin
    if (done) begin
      assert_single_result_R8: assert ($onehot({gt, eq, lt}));
      assert_gt_value_R5: assert (gt == (a_t > b_t));
      assert_lt_value_R6: assert (lt == (a_t < b_t));
      assert_eq_value_R7: assert (eq == (a_t == b_t));
    end else begin
      assert_quiet_until_done_R2: assert ({gt, eq, lt} == 3'b000);
    end
    if (ok != '1) begin
      assert_no_early_done_R4: assert (!done);
    end
  end
endmodule

// File: tb/dr_mag_compare_test.sv
module dr_mag_compare_test;
  localparam int N = 8;
  localparam int NV = 12;
  localparam logic [N-1:0] VA [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h5A, 8'hA5,
                                       8'h01, 8'h00, 8'hFF, 8'hFE, 8'h3C, 8'h81};
  localparam logic [N-1:0] VB [NV] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h5A, 8'h5A,
                                       8'h00, 8'h01, 8'h00, 8'hFF, 8'h3D, 8'h81};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] a_t, a_f, b_t, b_f;
  logic gt, eq, lt, done;
  logic a1_t, a1_f, b1_t, b1_f, gt1, eq1, lt1, done1;
  int checks = 0, errors = 0;
  bit finished = 0;

  dr_mag_compare #(.N(N)) uut (.a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
                               .gt(gt), .eq(eq), .lt(lt), .done(done));
  dr_mag_compare #(.N(1)) uut_one (.a_t(a1_t), .a_f(a1_f), .b_t(b1_t), .b_f(b1_f),
                                   .gt(gt1), .eq(eq1), .lt(lt1), .done(done1));

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic run_pair(input logic [N-1:0] va, input logic [N-1:0] vb);
    int order [2*N];
    int exp;
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    settle();
    chk(done == 0 && {gt, eq, lt} == 0, "R1", {done, gt, eq, lt}, 0);
    for (int k = 0; k < 2 * N; k++) order[k] = k;
    for (int k = 2 * N - 1; k > 0; k--) begin
      int j = int'($urandom_range(k, 0));
      int t = order[k];
      order[k] = order[j];
      order[j] = t;
    end
    for (int k = 0; k < 2 * N; k++) begin
      int s = order[k];
      if (s < N) begin a_t[s] = va[s]; a_f[s] = ~va[s]; end
      else begin b_t[s-N] = vb[s-N]; b_f[s-N] = ~vb[s-N]; end
      settle();
      if (k < 2 * N - 1)
        chk(done == 0 && {gt, eq, lt} == 0, "R2", {done, gt, eq, lt}, 0);
      else
        chk(done == 1, "R4", done, 1);
    end
    exp = (va > vb) ? 4 : (va == vb) ? 2 : 1;
    chk(gt == (va > vb), "R5", gt, va > vb);
    chk(lt == (va < vb), "R6", lt, va < vb);
    chk(eq == (va == vb), "R7", eq, va == vb);
    chk({gt, eq, lt} == exp[2:0], "R8", {gt, eq, lt}, exp);
  endtask

  initial begin
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    a1_t = 0; a1_f = 0; b1_t = 0; b1_f = 0;
    settle();
    chk(done == 0 && {gt, eq, lt} == 0, "R1", {done, gt, eq, lt}, 0);
    chk(done1 == 0 && {gt1, eq1, lt1} == 0, "R1", {done1, gt1, eq1, lt1}, 0);

    for (int v = 0; v < NV; v++) run_pair(VA[v], VB[v]);

    // R9: msb decides against opposing lower bits
    run_pair(8'h80, 8'h7F);
    chk(gt == 1 && lt == 0, "R9", {gt, lt}, 2);

    // R3: illegal both-high bit blocks completion
    a_t = 8'h12; a_f = ~8'h12; b_t = 8'h34; b_f = ~8'h34;
    a_t[3] = 1'b1; a_f[3] = 1'b1;
    settle();
    chk(done == 0 && {gt, eq, lt} == 0, "R3", {done, gt, eq, lt}, 0);
    a_f[3] = 1'b0;
    settle();
    chk(done == 1 && lt == 1, "R4", {done, lt}, 3);

    // R2: operand b left fully null
    b_t = '0; b_f = '0;
    settle();
    chk(done == 0 && {gt, eq, lt} == 0, "R2", {done, gt, eq, lt}, 0);

    // single-cell chain, all four combinations
    for (int c = 0; c < 4; c++) begin
      logic x, y;
      x = c[1]; y = c[0];
      a1_t = x; a1_f = ~x; b1_t = 0; b1_f = 0;
      settle();
      chk(done1 == 0, "R2", done1, 0);
      b1_t = y; b1_f = ~y;
      settle();
      chk(done1 == 1, "R4", done1, 1);
      chk(gt1 == (x & ~y), "R5", gt1, x & ~y);
      chk(lt1 == (~x & y), "R6", lt1, ~x & y);
      chk(eq1 == (x == y), "R7", eq1, x == y);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule